// File: doc/BRIEF.md
# Hibernate and Wakeup Sequencer

This block governs the supply of a chip from an always-on low-frequency domain, where one clock cycle is one tick. Software requests a power-down by writing a request bit. The block then drops its power-enable output and waits for an active-low wakeup pin. A glitch-filter count decides how long the pin must stay low before the wakeup is accepted. Once the wakeup is accepted, power returns at once. The reset output stays asserted for a programmed number of ticks and is then released.

Both timers come only from masked register fields. The filter limit keeps bits 15:5 of what was written and the reset-hold limit keeps bits 11:5. Every other bit is dropped on write and reads back as zero. The registers sit on a plain single-cycle write bus with a combinational read port.

Top module: `hws_seq`

## Requirements
- R1: After reset, pwr_en = 1, rst_out_n = 1, and offsets 0x20, 0x24 and 0x28 all read 0.
- R2: While running, a write with data bit 0 = 1 to offset 0x20 makes pwr_en and rst_out_n both 0 from the next clock edge. From then until the block is running again, offset 0x20 reads 1. A write to 0x20 with bit 0 = 0 has no effect.
- R3: Offset 0x24 (filter limit F) stores only data bits 15:5 (mask 0x0000FFE0). All other bits read back as 0.
- R4: Offset 0x28 (hold limit H) stores only data bits 11:5 (mask 0x00000FE0). All other bits read back as 0.
- R5: While hibernating, the wakeup is accepted at the clock edge that samples wake_n = 0 for the (F+1)th consecutive time. pwr_en returns to 1 at that edge, so F = 0 accepts the first low sample.
- R6: If wake_n is sampled high before acceptance, the block returns to hibernation and the consecutive count starts again from zero.
- R7: After acceptance, rst_out_n stays 0 for H+1 edges and rises at the (H+1)th edge. With H = 0 it rises at the next edge.
- R8: A power-down request written while the block is not running is ignored. The wake sequence keeps its timing and pwr_en is not dropped.
- R9: Writes to unmapped offsets have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at addr |
| wake_n | input | 1 | Active-low wakeup pin |
| pwr_en | output | 1 | Power enable, low while hibernating or filtering |
| rst_out_n | output | 1 | Active-low reset to the powered domain |

## Verification
The checker watches several rules on every cycle. Reset is always asserted while power is off, and a power-down request always takes effect on the next edge. Power only returns through an accepted wakeup, and a high pin during filtering always returns the block to hibernation. The reset release only comes out of the hold phase, and the read data never shows bits outside the field masks. The exact tick counts of the filter and the hold phases are shown only by the bench's scenarios, which count edges against the programmed limits. The same goes for the restart of the count after an aborted assertion and for requests ignored mid-sequence.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HIB, ST_FILT, ST_HOLD} seq_st_t;

  localparam logic [31:0] FILT_MASK = 32'h0000_FFE0;
  localparam logic [31:0] HOLD_MASK = 32'h0000_0FE0;

  function automatic logic [31:0] filt_field(input logic [31:0] v);
    return v & FILT_MASK;
  endfunction

  function automatic logic [31:0] hold_field(input logic [31:0] v);
    return v & HOLD_MASK;
  endfunction

  // true once the number of ticks already counted covers the limit
  function automatic logic limit_met(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/hws_regs.sv
module hws_regs
  import hws_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter logic [AW-1:0] OFS_SLEEP = 8'h20,
  parameter logic [AW-1:0] OFS_FILT  = 8'h24,
  parameter logic [AW-1:0] OFS_HOLD  = 8'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          asleep,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] filt_lim,
  output logic [LW-1:0] hold_lim,
  output logic          sleep_wr
);
  logic [DW-1:0] filt_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      hold_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_FILT) filt_q <= filt_field(wdata);
      if (addr == OFS_HOLD) hold_q <= hold_field(wdata);
    end
  end

  assign sleep_wr = wr_en && (addr == OFS_SLEEP) && wdata[0];
  assign filt_lim = filt_q[LW-1:0];
  assign hold_lim = hold_q[LW-1:0];

  always_comb begin
    rdata = '0;
    if (addr == OFS_SLEEP)     rdata = {{(DW-1){1'b0}}, asleep};
    else if (addr == OFS_FILT) rdata = filt_q;
    else if (addr == OFS_HOLD) rdata = hold_q;
  end
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
  import hws_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_wr,
  input  logic          wake_n,
  input  logic [LW-1:0] filt_lim,
  input  logic [LW-1:0] hold_lim,
  output seq_st_t       state,
  output logic          sleep_req,
  output logic          wake_ok,
  output logic          wake_abort,
  output logic          hold_done,
  output logic          pwr_en,
  output logic          rst_out_n
);
  seq_st_t       st, st_n;
  logic [LW-1:0] cnt, cnt_n;

  assign sleep_req  = (st == ST_RUN) && sleep_wr;
  assign wake_abort = (st == ST_FILT) && wake_n;
  assign wake_ok    = !wake_n &&
                      (((st == ST_HIB) && (filt_lim == '0)) ||
                       ((st == ST_FILT) && limit_met(cnt, filt_lim)));
  assign hold_done  = (st == ST_HOLD) && limit_met(cnt, hold_lim);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      ST_RUN:  if (sleep_req) st_n = ST_HIB;
      ST_HIB:  if (wake_ok) begin
                 st_n  = ST_HOLD;
                 cnt_n = '0;
               end else if (!wake_n) begin
                 st_n  = ST_FILT;
                 cnt_n = {{(LW-1){1'b0}}, 1'b1};
               end
      ST_FILT: if (wake_abort) begin
                 st_n  = ST_HIB;
                 cnt_n = '0;
               end else if (wake_ok) begin
                 st_n  = ST_HOLD;
                 cnt_n = '0;
               end else begin
                 cnt_n = cnt + 1'b1;
               end
      ST_HOLD: if (hold_done) st_n = ST_RUN;
               else           cnt_n = cnt + 1'b1;
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign state     = st;
  assign pwr_en    = (st == ST_RUN) || (st == ST_HOLD);
  assign rst_out_n = (st == ST_RUN);
endmodule

// File: rtl/hws_seq.sv
module hws_seq
  import hws_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] OFS_SLEEP = 8'h20,
  parameter logic [AW-1:0] OFS_FILT  = 8'h24,
  parameter logic [AW-1:0] OFS_HOLD  = 8'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          wake_n,
  output logic          pwr_en,
  output logic          rst_out_n
);
  localparam int LW = 16;

  seq_st_t       state;
  logic [LW-1:0] filt_lim, hold_lim;
  logic          sleep_wr, sleep_req, wake_ok, wake_abort, hold_done;

  hws_regs #(
    .AW(AW), .DW(DW), .LW(LW),
    .OFS_SLEEP(OFS_SLEEP), .OFS_FILT(OFS_FILT), .OFS_HOLD(OFS_HOLD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .asleep(state != ST_RUN), .rdata(rdata),
    .filt_lim(filt_lim), .hold_lim(hold_lim), .sleep_wr(sleep_wr)
  );

  hws_fsm #(.LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .wake_n(wake_n),
    .filt_lim(filt_lim), .hold_lim(hold_lim), .state(state),
    .sleep_req(sleep_req), .wake_ok(wake_ok), .wake_abort(wake_abort),
    .hold_done(hold_done), .pwr_en(pwr_en), .rst_out_n(rst_out_n)
  );
endmodule

// File: rtl/hws_chk.sv
module hws_chk
  import hws_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] OFS_FILT = 8'h24,
  parameter logic [AW-1:0] OFS_HOLD = 8'h28
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          wake_n,
  input logic          pwr_en,
  input logic          rst_out_n,
  input seq_st_t       state,
  input logic          sleep_req,
  input logic          wake_ok
);
  a_r2_off_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!pwr_en && !rst_out_n));

  a_r2_reset_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !rst_out_n);

  a_r5_power_via_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(wake_ok));

  a_r6_abort_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILT && wake_n) |=> (state == ST_HIB));

  a_r7_release_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(state) == ST_HOLD && $past(pwr_en)));

  a_r3_filt_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_FILT) |-> ((rdata & ~FILT_MASK) == '0));

  a_r4_hold_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_HOLD) |-> ((rdata & ~HOLD_MASK) == '0));

  a_r8_no_sleep_mid_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> (state != ST_HIB));
endmodule

bind hws_seq hws_chk #(.AW(AW), .DW(DW), .OFS_FILT(OFS_FILT), .OFS_HOLD(OFS_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .wake_n(wake_n),
  .pwr_en(pwr_en), .rst_out_n(rst_out_n), .state(state),
  .sleep_req(sleep_req), .wake_ok(wake_ok)
);

// File: tb/sim_hws_seq.sv
`timescale 1ns/1ps
module sim_hws_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake_n = 1'b1;
  logic        pwr_en, rst_out_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hws_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wake_n(wake_n), .pwr_en(pwr_en), .rst_out_n(rst_out_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 8'h00;
  endtask

  task automatic go_sleep();
    wr(8'h20, 32'h1);
    chk("R2 pwr_en", {31'b0, pwr_en}, 0);
    chk("R2 rst_out_n", {31'b0, rst_out_n}, 0);
  endtask

  // pin goes low; expect acceptance at edge f+1, then release h+1 edges later
  task automatic wake_and_hold(input int f, input int h, input string rq);
    @(negedge clk);
    wake_n = 1'b0;
    for (int i = 1; i <= f + 1; i++) begin
      @(negedge clk);
      if (i == f + 1 || i == f || i == 1)
        chk(rq, {31'b0, pwr_en}, (i == f + 1) ? 1 : 0);
    end
    wake_n = 1'b1;
    for (int j = 1; j <= h + 1; j++) begin
      if (j == 1 || j == h || j == h + 1) begin
        chk("R7 held", {31'b0, rst_out_n}, 0);
      end
      @(negedge clk);
      if (j == h + 1) chk("R7 release", {31'b0, rst_out_n}, 1);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pwr_en", {31'b0, pwr_en}, 1);
    chk("R1 rst_out_n", {31'b0, rst_out_n}, 1);
    rd(8'h20, v); chk("R1 sleep reg", v, 0);
    rd(8'h24, v); chk("R1 filt reg", v, 0);
    rd(8'h28, v); chk("R1 hold reg", v, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk("R3 filt all ones", v, 32'h0000_FFE0);
    wr(8'h24, 32'd3200);      rd(8'h24, v); chk("R3 filt 3200", v, 32'd3200);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R4 hold all ones", v, 32'h0000_0FE0);
    wr(8'h28, 32'h0000_101F); rd(8'h28, v); chk("R4 hold low bits", v, 0);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); chk("R9 unmapped read", v, 0);
    rd(8'h24, v); chk("R9 filt untouched", v, 32'd3200);
    wr(8'h20, 32'h2);
    chk("R2 bit0 clear ignored", {31'b0, pwr_en}, 1);
    rd(8'h20, v); chk("R2 still running", v, 0);
  endtask

  task automatic t_default_wake();
    logic [31:0] v;
    wr(8'h28, 32'd1920);  // 60 ms worth, lands on 0x780
    go_sleep();
    rd(8'h20, v); chk("R2 asleep reads 1", v, 1);
    wake_and_hold(3200, 1920, "R5 F=3200");
    rd(8'h20, v); chk("R2 awake reads 0", v, 0);
  endtask

  task automatic t_abort();
    wr(8'h24, 32'h3F);  // F = 32
    wr(8'h28, 32'h40);  // H = 64
    go_sleep();
    @(negedge clk);
    wake_n = 1'b0;
    repeat (20) @(negedge clk);
    wake_n = 1'b1;
    @(negedge clk);
    chk("R6 aborted stays off", {31'b0, pwr_en}, 0);
    wake_and_hold(32, 64, "R6 restart F=32");
  endtask

  task automatic t_zero();
    wr(8'h24, 32'h1F);
    wr(8'h28, 32'h0);
    go_sleep();
    wake_and_hold(0, 0, "R5 F=0");
  endtask

  task automatic t_ignore();
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h20);  // H = 32
    go_sleep();
    @(negedge clk);
    wake_n = 1'b0;
    @(negedge clk);
    wake_n = 1'b1;
    chk("R8 accepted", {31'b0, pwr_en}, 1);
    wr_en = 1'b1; addr = 8'h20; wdata = 32'h1;
    for (int j = 1; j <= 33; j++) begin
      @(negedge clk);
      wr_en = 1'b0; addr = 8'h00;
      if (j == 1 || j == 32 || j == 33) begin
        chk("R8 power kept", {31'b0, pwr_en}, 1);
        chk("R8 release timing", {31'b0, rst_out_n}, (j == 33) ? 1 : 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_default_wake();
    t_abort();
    t_zero();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule